// File: doc/BRIEF.md
# Oversampled Rate Control with Deadband

This block turns a stream of noisy 10-bit converter readings into a steady 16-bit oscillator rate word. Every accepted reading is added to a running sum. When a fixed window of readings is complete, the sum is scaled down, a minimum-rate offset is added, and the result becomes a candidate rate. The candidate replaces the held rate only if the two differ by at least a deadband threshold. This stops the rate from flickering between neighbouring values when the input hovers near a converter step. The sum then clears, whatever the decision was, and the next window begins.

Readings arrive on a valid/ready stream. The block never applies back-pressure once it is out of reset. `in_ready` is low only while reset is asserted and during the first clock after reset is released, and it then stays high. A reading is consumed on each rising edge at which `in_valid` and `in_ready` are both high. The rate word is a plain output. A one-clock pulse marks every change of that word.

Top module: `rate_ctrl_deadband`

## Requirements
- R1: While reset is asserted, `rate` is 0x0080, `rate_upd` is 0 and `in_ready` is 0.
- R2: From the second rising edge after reset is released, `in_ready` is 1. A reading is taken only when `in_valid` is 1 at a rising edge, and data presented while `in_valid` is 0 has no effect on the sum.
- R3: No decision is made until 2^LOG2_WINDOW readings have been accepted (256 by default). After fewer readings, `rate` holds its value and `rate_upd` stays 0.
- R4: The candidate is the window sum shifted right by 4 bits plus the offset 0x0080. `rate` therefore never falls below 0x0080.
- R5: When the absolute difference between the candidate and `rate` is below 0x10, `rate` is unchanged and no pulse is given.
- R6: When that difference is 0x10 or more, whether upward or downward, `rate` is loaded with the candidate.
- R7: `rate_upd` is high for exactly one clock, in the same cycle as each change of `rate`. Both change on the rising edge that follows the edge accepting the last reading of the window.
- R8: The sum restarts from zero at the end of every window, whether or not `rate` changed.
- R9: The sum is wide enough for a full window of maximum readings (0x3FF) without overflow, so such a window yields exactly the expected candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A reading is present on `in_data` |
| in_ready | output | 1 | The block accepts a reading this cycle |
| in_data | input | SAMPLE_W | Unsigned converter reading |
| rate | output | RATE_W | Held oscillator rate word |
| rate_upd | output | 1 | One-clock pulse when `rate` changes |

## Verification
The bench builds the block with LOG2_WINDOW = 3, so a window is 8 readings and the rest of the parameters keep their defaults. With 8 equal readings of value v, the candidate is 0x0080 + floor(v/2). This places candidates exactly 15 and 16 steps away from the held rate, in both directions, within reach of single windows. It also makes partial windows, stream gaps and back-to-back windows cheap enough to cover each in its own directed scenario.

// File: rtl/rate_ctrl_pkg.sv
package rate_ctrl_pkg;

  typedef enum logic {
    DEC_HOLD = 1'b0,
    DEC_LOAD = 1'b1
  } rate_dec_e;

  localparam int DEF_SAMPLE_W    = 10;
  localparam int DEF_RATE_W      = 16;
  localparam int DEF_LOG2_WINDOW = 8;
  localparam int DEF_SHIFT       = 4;
  localparam int DEF_MIN_RATE    = 16'h0080;
  localparam int DEF_DEADBAND    = 16'h0010;

endpackage

// File: rtl/rate_accum.sv
module rate_accum #(
  parameter int SAMPLE_W    = 10,
  parameter int LOG2_WINDOW = 8,
  localparam int SUM_W      = SAMPLE_W + LOG2_WINDOW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                win_valid,
  output logic [SUM_W-1:0]    win_sum
);

  logic [LOG2_WINDOW-1:0] cnt_q;
  logic [SUM_W-1:0]       sum_q;
  logic [SUM_W-1:0]       sum_nx;
  logic                   last;

  assign sum_nx = sum_q + SUM_W'(sample);
  assign last   = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      sum_q     <= '0;
      win_valid <= 1'b0;
      win_sum   <= '0;
    end else begin
      win_valid <= 1'b0;
      if (take) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          win_sum   <= sum_nx;
          win_valid <= 1'b1;
          sum_q     <= '0;
        end else begin
          sum_q <= sum_nx;
        end
      end
    end
  end

endmodule

// File: rtl/rate_deadband.sv
module rate_deadband
  import rate_ctrl_pkg::*;
#(
  parameter int SUM_W    = 18,
  parameter int RATE_W   = 16,
  parameter int SHIFT    = 4,
  parameter int MIN_RATE = 16'h0080,
  parameter int DEADBAND = 16'h0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_valid,
  input  logic [SUM_W-1:0]  win_sum,
  output logic [RATE_W-1:0] rate,
  output logic              rate_upd
);

  localparam logic [RATE_W-1:0] MIN_W = RATE_W'(MIN_RATE);
  localparam logic [RATE_W:0]   DB_W  = (RATE_W+1)'(DEADBAND);

  logic [SUM_W-1:0]  scaled;
  logic [RATE_W-1:0] cand;
  logic [RATE_W:0]   diff;
  logic [RATE_W:0]   mag;
  rate_dec_e         dec;

  assign scaled = win_sum >> SHIFT;
  assign cand   = RATE_W'(scaled) + MIN_W;
  assign diff   = {1'b0, cand} - {1'b0, rate};
  assign mag    = diff[RATE_W] ? (~diff + 1'b1) : diff;

  always_comb begin
    dec = DEC_HOLD;
    if (win_valid && (mag >= DB_W)) dec = DEC_LOAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate     <= MIN_W;
      rate_upd <= 1'b0;
    end else begin
      rate_upd <= (dec == DEC_LOAD);
      if (dec == DEC_LOAD) rate <= cand;
    end
  end

endmodule

// File: rtl/rate_ctrl_deadband.sv
module rate_ctrl_deadband
  import rate_ctrl_pkg::*;
#(
  parameter int SAMPLE_W    = DEF_SAMPLE_W,
  parameter int RATE_W      = DEF_RATE_W,
  parameter int LOG2_WINDOW = DEF_LOG2_WINDOW,
  parameter int SHIFT       = DEF_SHIFT,
  parameter int MIN_RATE    = DEF_MIN_RATE,
  parameter int DEADBAND    = DEF_DEADBAND
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic [RATE_W-1:0]   rate,
  output logic                rate_upd
);

  localparam int SUM_W = SAMPLE_W + LOG2_WINDOW;

  logic             ready_q;
  logic             take;
  logic             win_valid;
  logic [SUM_W-1:0] win_sum;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign take     = in_valid & ready_q;

  rate_accum #(
    .SAMPLE_W   (SAMPLE_W),
    .LOG2_WINDOW(LOG2_WINDOW)
  ) u_accum (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .sample   (in_data),
    .win_valid(win_valid),
    .win_sum  (win_sum)
  );

  rate_deadband #(
    .SUM_W   (SUM_W),
    .RATE_W  (RATE_W),
    .SHIFT   (SHIFT),
    .MIN_RATE(MIN_RATE),
    .DEADBAND(DEADBAND)
  ) u_dband (
    .clk      (clk),
    .rst      (rst),
    .win_valid(win_valid),
    .win_sum  (win_sum),
    .rate     (rate),
    .rate_upd (rate_upd)
  );

endmodule

// File: rtl/rate_ctrl_checker.sv
module rate_ctrl_checker #(
  parameter int RATE_W      = 16,
  parameter int LOG2_WINDOW = 8,
  parameter int MIN_RATE    = 16'h0080,
  parameter int DEADBAND    = 16'h0010
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [RATE_W-1:0] rate,
  input logic              rate_upd
);

  logic [LOG2_WINDOW-1:0] n_q;
  logic                   done1_q, done2_q, live_q;
  logic [RATE_W-1:0]      prev_q;
  logic [RATE_W:0]        step;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q <= '0; done1_q <= 1'b0; done2_q <= 1'b0; live_q <= 1'b0;
      prev_q <= RATE_W'(MIN_RATE);
    end else begin
      live_q  <= 1'b1;
      done2_q <= done1_q;
      done1_q <= in_valid && in_ready && (&n_q);
      if (in_valid && in_ready) n_q <= n_q + 1'b1;
      prev_q <= rate;
    end
  end

  assign step = (rate >= prev_q) ? {1'b0, rate - prev_q} : {1'b0, prev_q - rate};

  assert_ready_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
    live_q |-> in_ready);
  assert_upd_needs_window_R3: assert property (@(posedge clk) disable iff (rst)
    rate_upd |-> done2_q);
  assert_rate_floor_R4: assert property (@(posedge clk) disable iff (rst)
    rate >= RATE_W'(MIN_RATE));
  assert_step_size_R6: assert property (@(posedge clk) disable iff (rst)
    rate_upd |-> step >= (RATE_W+1)'(DEADBAND));
  assert_change_flagged_R7: assert property (@(posedge clk) disable iff (rst)
    (rate != prev_q) |-> rate_upd);
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rate_upd |=> !rate_upd);

endmodule

bind rate_ctrl_deadband rate_ctrl_checker #(
  .RATE_W     (RATE_W),
  .LOG2_WINDOW(LOG2_WINDOW),
  .MIN_RATE   (MIN_RATE),
  .DEADBAND   (DEADBAND)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .rate    (rate),
  .rate_upd(rate_upd)
);

// File: tb/sim_rate_ctrl_deadband.sv
module sim_rate_ctrl_deadband;

  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [9:0]  in_data = '0;
  logic [15:0] rate;
  logic        rate_upd;

  int tests = 0, fails = 0;
  int pulses = 0, exp_pulses = 0;
  int exp_rate = 16'h0080;
  int pend_sum = 0, pend_cnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rate_ctrl_deadband #(.LOG2_WINDOW(3)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rate(rate), .rate_upd(rate_upd)
  );

  always @(negedge clk) if (!rst && rate_upd) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // model of the window decision, from the requirements
  task automatic model_take(input int v);
    int cand, d;
    pend_sum += v;
    pend_cnt++;
    if (pend_cnt == WIN) begin
      cand = (pend_sum >> 4) + 16'h0080;
      d = (cand > exp_rate) ? cand - exp_rate : exp_rate - cand;
      if (d >= 16'h10) begin
        exp_rate = cand;
        exp_pulses++;
      end
      pend_sum = 0;
      pend_cnt = 0;
    end
  endtask

  // drive n readings v0, v0+step, ... (10-bit wrap); optional junk gap cycles
  task automatic feed(input int v0, input int stp, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      int v;
      v = (v0 + stp * i) & 10'h3FF;
      in_valid = 1'b1;
      in_data  = 10'(v);
      @(posedge clk);
      model_take(v);
      @(negedge clk);
      if (gaps) begin
        in_valid = 1'b0;
        in_data  = 10'h3FF;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_data  = 10'h000;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_state(input string req);
    chk(rate == 16'(exp_rate), req, rate, exp_rate);
    chk(pulses == exp_pulses, {req, " pulses"}, pulses, exp_pulses);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rate == 16'h0080, "R1 rate", rate, 16'h0080);
    chk(rate_upd == 1'b0, "R1 upd", rate_upd, 0);
    chk(in_ready == 1'b0, "R1 ready", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready", in_ready, 1);
  endtask

  task automatic t_zero_window();   // candidate 0x80 equals held: R5, R4
    feed(0, 0, WIN, 1'b0);
    check_state("R5 zero window");
  endtask

  task automatic t_max_window();    // full-scale readings: R9, R6 up
    feed(10'h3FF, 0, WIN, 1'b0);
    chk(exp_rate == 16'h027F, "R9 model", exp_rate, 16'h027F);
    check_state("R9 max window");
  endtask

  task automatic t_boundaries();    // R5 / R6 at 15 and 16 steps
    feed(993, 0, WIN, 1'b0);        // 0x270: 15 below
    check_state("R5 down 15");
    feed(990, 0, WIN, 1'b0);        // 0x26F: 16 below
    chk(rate == 16'h026F, "R6 down 16", rate, 16'h026F);
    feed(1020, 0, WIN, 1'b0);       // 0x27E: 15 above
    check_state("R5 up 15");
    feed(1022, 0, WIN, 1'b0);       // 0x27F: 16 above
    chk(rate == 16'h027F, "R6 up 16", rate, 16'h027F);
    check_state("R6 boundary pulses");
  endtask

  task automatic t_partial();       // R3 partial window, R2 gaps, R7 timing
    int p0;
    feed(0, 0, WIN - 1, 1'b1);
    chk(rate == 16'h027F, "R3 partial hold", rate, 16'h027F);
    check_state("R3 partial");
    p0 = pulses;
    in_valid = 1'b1; in_data = 10'h000;
    @(posedge clk);                 // last reading accepted here
    model_take(0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(rate == 16'h027F, "R7 not before", rate, 16'h027F);
    @(negedge clk);                 // one edge later: change and pulse
    chk(rate == 16'h0080, "R7 rate", rate, 16'h0080);
    chk(rate_upd == 1'b1, "R7 pulse", rate_upd, 1);
    @(negedge clk);
    chk(rate_upd == 1'b0, "R7 pulse end", rate_upd, 0);
    chk(pulses == p0 + 1, "R7 width", pulses, p0 + 1);
  endtask

  task automatic t_clear();         // R8 back-to-back windows with varied data
    feed(5, 100, WIN, 1'b0);
    check_state("R8 ramp");
    feed(700, 37, WIN, 1'b1);
    check_state("R8 second");
    feed(0, 0, WIN, 1'b0);
    check_state("R8 third");
    chk(rate >= 16'h0080, "R4 floor", rate, 16'h0080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_zero_window();
    t_max_window();
    t_boundaries();
    t_partial();
    t_clear();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule